// File: doc/BRIEF.md
# Protected Module Slot Controller

This controller manages a fixed, parameter-sized set of hardware slots. Each slot guards one protected software module. A module's layout is two half-open address spans: a code span `[code_lo, code_hi)` and a private data span `[data_lo, data_hi)`. Every cycle the controller passes the fetch address and the fetch address of the cycle before to all slots. The slots all evaluate their access rules in parallel. Any slot that flags a breach makes the controller raise a core reset request. That request comes from a flop, so a combinational glitch cannot reach the core's reset.

Software drives three operations. Protect registers a new layout. It is refused if the layout is malformed, if it overlaps any live module, or if no slot is free. A successful protect takes the lowest free slot and hands out the next number from a counter. The counter starts at 1 and only moves forward, so numbers are never handed out twice between resets. Release frees the slot whose code span holds the current fetch address, which means only the module itself can release its own slot. Lookup returns the number of the live module whose code span covers a given address, or 0 when no live module covers it.

Top module: `pm_slot_ctrl`

## Requirements
- R1: While reset is active, and after it is released, `status_o` is 0 (idle), `id_o` is 0 and `core_rst_o` is 0. All slots start free.
- R2: A protect with a valid, non-overlapping layout and a free slot gives `status_o`=1 (ok) and a non-zero `id_o` in the cycle after the request. The numbers run 1, 2, 3, … in the order of successful protects.
- R3: A protect whose code or data span intersects the code or data span of any live module gives `status_o`=2 (fail) and `id_o`=0, and uses up no number.
- R4: A protect when every slot is live gives `status_o`=2 and `id_o`=0.
- R5: A protect with `code_lo >= code_hi` or `data_lo >= data_hi` gives `status_o`=2 and `id_o`=0.
- R6: A number freed by release is never handed out again. The next successful protect gets the next number in the sequence.
- R7: A release frees the live slot whose code span holds `pc_i` and gives `status_o`=1 with `id_o`=0 one cycle later. If no such slot exists, the result is `status_o`=2 and `id_o`=0.
- R8: A lookup gives `status_o`=1 one cycle later. `id_o` is the number of the live module with `code_lo <= addr < code_hi`, or 0 if there is none.
- R9: A breach is flagged when the fetch address lands inside a live code span, the previous fetch address lay outside that span, and the fetch address is not the span's first address.
- R10: A breach is flagged when a data access hits a live data span while the fetch address is outside that module's code span. A breach is also flagged when any write hits a live code span.
- R11: When several requests arrive in one cycle, protect wins over release, and release wins over lookup. Only the winner takes effect.
- R12: `core_rst_o` follows the OR of all breach flags through one flop. It does not change in the cycle of the breach. It rises after the next edge and falls one edge after the breach ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| pc_i | input | 16 | current fetch address |
| mem_req_i | input | 1 | data access valid |
| mem_we_i | input | 1 | data access is a write |
| mem_addr_i | input | 16 | data access address |
| prot_req_i | input | 1 | protect request |
| code_lo_i | input | 16 | new code span start |
| code_hi_i | input | 16 | new code span end (exclusive) |
| data_lo_i | input | 16 | new data span start |
| data_hi_i | input | 16 | new data span end (exclusive) |
| unprot_req_i | input | 1 | release request |
| getid_req_i | input | 1 | lookup request |
| getid_addr_i | input | 16 | lookup address |
| status_o | output | 2 | 0 idle, 1 ok, 2 fail |
| id_o | output | 16 | returned module number |
| core_rst_o | output | 1 | registered reset request |

## Verification
Protect, release and lookup results are registered. They are due on the first edge after the request, so the bench applies each request just after a falling edge and reads the result at the next falling edge. The breach flag passes through one flop. After driving a breaching fetch or access, the bench first checks that `core_rst_o` is still low in the same cycle. It then checks the flag one edge later, and checks that it clears one edge after the stimulus is removed. A bench-side model of the slot table supplies every expected number and status, including a sweep of lookups over the address space and the span edges.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int PM_AW = 16;

    typedef logic [PM_AW-1:0] addr_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OK   = 2'd1,
        ST_FAIL = 2'd2
    } stat_e;

    typedef struct packed {
        addr_t code_lo;
        addr_t code_hi;
        addr_t data_lo;
        addr_t data_hi;
    } layout_t;

    function automatic logic in_span(addr_t a, addr_t lo, addr_t hi);
        return (a >= lo) && (a < hi);
    endfunction

    function automatic logic spans_meet(addr_t lo1, addr_t hi1, addr_t lo2, addr_t hi2);
        return (lo1 < hi2) && (lo2 < hi1);
    endfunction

    function automatic logic layout_valid(layout_t l);
        return (l.code_lo < l.code_hi) && (l.data_lo < l.data_hi);
    endfunction

endpackage

// File: rtl/pm_pick_free.sv
module pm_pick_free #(
    parameter int N = 4
) (
    input  logic [N-1:0] busy_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    always_comb begin
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                grant_o = '0;
                grant_o[i] = 1'b1;
            end
        end
    end

    assign any_o = ~&busy_i;
endmodule

// File: rtl/pm_slot.sv
module pm_slot
    import pm_pkg::*;
#(
    parameter int IDW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic           clr_i,
    input  layout_t        lay_i,
    input  logic [IDW-1:0] id_i,
    input  addr_t          pc_cur_i,
    input  addr_t          pc_prev_i,
    input  logic           mem_req_i,
    input  logic           mem_we_i,
    input  addr_t          mem_addr_i,
    input  addr_t          query_i,
    output logic           en_o,
    output logic [IDW-1:0] id_o,
    output logic           pc_hit_o,
    output logic           q_hit_o,
    output logic           ovl_o,
    output logic           viol_o
);
    layout_t lay_q;
    logic    cur_in, prev_in, bad_entry, bad_data, bad_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o  <= 1'b0;
            lay_q <= '0;
            id_o  <= '0;
        end else if (load_i) begin
            en_o  <= 1'b1;
            lay_q <= lay_i;
            id_o  <= id_i;
        end else if (clr_i) begin
            en_o  <= 1'b0;
        end
    end

    always_comb begin
        cur_in    = in_span(pc_cur_i, lay_q.code_lo, lay_q.code_hi);
        prev_in   = in_span(pc_prev_i, lay_q.code_lo, lay_q.code_hi);
        pc_hit_o  = en_o && cur_in;
        q_hit_o   = en_o && in_span(query_i, lay_q.code_lo, lay_q.code_hi);
        ovl_o     = en_o && (
                    spans_meet(lay_i.code_lo, lay_i.code_hi, lay_q.code_lo, lay_q.code_hi) ||
                    spans_meet(lay_i.code_lo, lay_i.code_hi, lay_q.data_lo, lay_q.data_hi) ||
                    spans_meet(lay_i.data_lo, lay_i.data_hi, lay_q.code_lo, lay_q.code_hi) ||
                    spans_meet(lay_i.data_lo, lay_i.data_hi, lay_q.data_lo, lay_q.data_hi));
        bad_entry = cur_in && !prev_in && (pc_cur_i != lay_q.code_lo);
        bad_data  = mem_req_i && in_span(mem_addr_i, lay_q.data_lo, lay_q.data_hi) && !cur_in;
        bad_wr    = mem_req_i && mem_we_i && in_span(mem_addr_i, lay_q.code_lo, lay_q.code_hi);
        viol_o    = en_o && (bad_entry || bad_data || bad_wr);
    end

    // R2: a slot is only loaded while it is free
    a_r2_load_free: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !en_o);

    // R7: a slot is only released by code running inside it
    a_r7_clr_own: assert property (@(posedge clk) disable iff (rst)
        clr_i |-> pc_hit_o);

    // R7: a released slot is free on the next cycle
    a_r7_clr_frees: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !load_i) |=> !en_o);
endmodule

// File: rtl/pm_slot_ctrl.sv
module pm_slot_ctrl
    import pm_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int IDW       = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PM_AW-1:0]    pc_i,
    input  logic                mem_req_i,
    input  logic                mem_we_i,
    input  logic [PM_AW-1:0]    mem_addr_i,
    input  logic                prot_req_i,
    input  logic [PM_AW-1:0]    code_lo_i,
    input  logic [PM_AW-1:0]    code_hi_i,
    input  logic [PM_AW-1:0]    data_lo_i,
    input  logic [PM_AW-1:0]    data_hi_i,
    input  logic                unprot_req_i,
    input  logic                getid_req_i,
    input  logic [PM_AW-1:0]    getid_addr_i,
    output logic [1:0]          status_o,
    output logic [IDW-1:0]      id_o,
    output logic                core_rst_o
);
    addr_t               pc_prev;
    layout_t             lay_new;
    logic [NUM_SLOTS-1:0] en_v, pc_hit_v, q_hit_v, ovl_v, viol_v;
    logic [NUM_SLOTS-1:0] grant_v, load_v, clr_v;
    logic [IDW-1:0]      ids [NUM_SLOTS];
    logic [IDW-1:0]      next_id, found_id;
    logic                free_any, prot_go, unp_sel, unp_go, viol_any;
    stat_e               stat_q;

    assign lay_new = '{code_lo: code_lo_i, code_hi: code_hi_i,
                       data_lo: data_lo_i, data_hi: data_hi_i};

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        pm_slot #(.IDW(IDW)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .load_i    (load_v[g]),
            .clr_i     (clr_v[g]),
            .lay_i     (lay_new),
            .id_i      (next_id),
            .pc_cur_i  (pc_i),
            .pc_prev_i (pc_prev),
            .mem_req_i (mem_req_i),
            .mem_we_i  (mem_we_i),
            .mem_addr_i(mem_addr_i),
            .query_i   (getid_addr_i),
            .en_o      (en_v[g]),
            .id_o      (ids[g]),
            .pc_hit_o  (pc_hit_v[g]),
            .q_hit_o   (q_hit_v[g]),
            .ovl_o     (ovl_v[g]),
            .viol_o    (viol_v[g])
        );
    end

    pm_pick_free #(.N(NUM_SLOTS)) u_pick (
        .busy_i (en_v),
        .grant_o(grant_v),
        .any_o  (free_any)
    );

    always_comb begin
        prot_go  = prot_req_i && layout_valid(lay_new) && !(|ovl_v) && free_any;
        load_v   = prot_go ? grant_v : '0;
        unp_sel  = !prot_req_i && unprot_req_i;
        unp_go   = unp_sel && (|pc_hit_v);
        clr_v    = unp_go ? pc_hit_v : '0;
        viol_any = |viol_v;
        found_id = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (q_hit_v[i]) found_id = found_id | ids[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_prev    <= '0;
            core_rst_o <= 1'b0;
            next_id    <= IDW'(1);
            stat_q     <= ST_IDLE;
            id_o       <= '0;
        end else begin
            pc_prev    <= pc_i;
            core_rst_o <= viol_any;
            if (prot_req_i) begin
                stat_q <= prot_go ? ST_OK : ST_FAIL;
                id_o   <= prot_go ? next_id : '0;
                if (prot_go) next_id <= next_id + IDW'(1);
            end else if (unprot_req_i) begin
                stat_q <= unp_go ? ST_OK : ST_FAIL;
                id_o   <= '0;
            end else if (getid_req_i) begin
                stat_q <= ST_OK;
                id_o   <= found_id;
            end else begin
                stat_q <= ST_IDLE;
                id_o   <= '0;
            end
        end
    end

    assign status_o = stat_q;

    // R12: the reset request follows the combined breach flag by exactly one edge
    a_r12_rst_follows: assert property (@(posedge clk) disable iff (rst)
        viol_any |=> core_rst_o);
    a_r12_rst_clears: assert property (@(posedge clk) disable iff (rst)
        !viol_any |=> !core_rst_o);

    // R3: refusing overlaps keeps every address covered by at most one live code span
    a_r3_single_cover: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pc_hit_v) && $onehot0(q_hit_v));

    // R2: a protect that succeeds returns a non-zero number
    a_r2_nonzero_id: assert property (@(posedge clk) disable iff (rst)
        prot_req_i |=> (status_o == ST_FAIL) || (id_o != '0));

    // R6: the number counter only ever stays or steps by one
    a_r6_id_forward: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (next_id == $past(next_id)) || (next_id == IDW'($past(next_id) + IDW'(1))));

    // R11: at most one slot is loaded per cycle, and never while another is released
    a_r11_single_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_v) && !((|load_v) && (|clr_v)));

    // R8: a lookup that hits nothing returns zero
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (getid_req_i && !prot_req_i && !unprot_req_i && !(|q_hit_v)) |=> (id_o == '0));
endmodule

// File: tb/pm_slot_ctrl_tb.sv
`timescale 1ns/1ps
module pm_slot_ctrl_tb;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pc_i = 16'hF000;
    logic        mem_req_i = 1'b0, mem_we_i = 1'b0;
    logic [15:0] mem_addr_i = '0;
    logic        prot_req_i = 1'b0;
    logic [15:0] code_lo_i = '0, code_hi_i = '0, data_lo_i = '0, data_hi_i = '0;
    logic        unprot_req_i = 1'b0, getid_req_i = 1'b0;
    logic [15:0] getid_addr_i = '0;
    logic [1:0]  status_o;
    logic [15:0] id_o;
    logic        core_rst_o;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the slot table
    logic [15:0] m_cl [NS], m_ch [NS], m_dl [NS], m_dh [NS], m_id [NS];
    logic        m_en [NS];
    logic [15:0] m_next = 16'd1;

    always #2 clk = ~clk;

    pm_slot_ctrl #(.NUM_SLOTS(NS), .IDW(16)) u_dut (
        .clk(clk), .rst(rst), .pc_i(pc_i), .mem_req_i(mem_req_i), .mem_we_i(mem_we_i),
        .mem_addr_i(mem_addr_i), .prot_req_i(prot_req_i), .code_lo_i(code_lo_i),
        .code_hi_i(code_hi_i), .data_lo_i(data_lo_i), .data_hi_i(data_hi_i),
        .unprot_req_i(unprot_req_i), .getid_req_i(getid_req_i), .getid_addr_i(getid_addr_i),
        .status_o(status_o), .id_o(id_o), .core_rst_o(core_rst_o)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic meet(logic [15:0] a0, a1, b0, b1);
        return (a0 < b1) && (b0 < a1);
    endfunction

    function automatic logic [15:0] m_lookup(logic [15:0] a);
        for (int i = 0; i < NS; i++)
            if (m_en[i] && a >= m_cl[i] && a < m_ch[i]) return m_id[i];
        return 16'd0;
    endfunction

    task automatic m_protect(logic [15:0] cl, ch, dl, dh, output logic ok, output logic [15:0] eid);
        int slot = -1;
        ok = (cl < ch) && (dl < dh);
        for (int i = 0; i < NS; i++) begin
            if (m_en[i] && (meet(cl, ch, m_cl[i], m_ch[i]) || meet(cl, ch, m_dl[i], m_dh[i]) ||
                            meet(dl, dh, m_cl[i], m_ch[i]) || meet(dl, dh, m_dl[i], m_dh[i])))
                ok = 1'b0;
            if (!m_en[i] && slot < 0) slot = i;
        end
        if (slot < 0) ok = 1'b0;
        eid = 16'd0;
        if (ok) begin
            m_en[slot] = 1'b1; m_cl[slot] = cl; m_ch[slot] = ch;
            m_dl[slot] = dl; m_dh[slot] = dh; m_id[slot] = m_next;
            eid = m_next; m_next++;
        end
    endtask

    task automatic do_protect(string tag, logic [15:0] cl, ch, dl, dh);
        logic ok; logic [15:0] eid;
        m_protect(cl, ch, dl, dh, ok, eid);
        prot_req_i = 1'b1; code_lo_i = cl; code_hi_i = ch; data_lo_i = dl; data_hi_i = dh;
        @(negedge clk);
        prot_req_i = 1'b0;
        chk({tag, " status"}, 32'(status_o), ok ? 32'd1 : 32'd2);
        chk({tag, " id"}, 32'(id_o), 32'(eid));
    endtask

    task automatic do_unprotect(string tag);
        logic hit = 1'b0;
        for (int i = 0; i < NS; i++)
            if (m_en[i] && pc_i >= m_cl[i] && pc_i < m_ch[i]) begin m_en[i] = 1'b0; hit = 1'b1; end
        unprot_req_i = 1'b1;
        @(negedge clk);
        unprot_req_i = 1'b0;
        chk({tag, " status"}, 32'(status_o), hit ? 32'd1 : 32'd2);
        chk({tag, " id"}, 32'(id_o), 32'd0);
    endtask

    task automatic do_getid(string tag, logic [15:0] a);
        getid_req_i = 1'b1; getid_addr_i = a;
        @(negedge clk);
        getid_req_i = 1'b0;
        chk({tag, " status"}, 32'(status_o), 32'd1);
        chk({tag, " id"}, 32'(id_o), 32'(m_lookup(a)));
    endtask

    task automatic set_pc(string tag, logic [15:0] a, logic exp_rst);
        pc_i = a;
        @(negedge clk);
        chk(tag, 32'(core_rst_o), 32'(exp_rst));
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) m_en[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 status in reset", 32'(status_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 status", 32'(status_o), 32'd0);
        chk("R1 id", 32'(id_o), 32'd0);
        chk("R1 core_rst", 32'(core_rst_o), 32'd0);

        do_protect("R2 first", 16'h1000, 16'h1100, 16'h2000, 16'h2100);
        do_protect("R3 overlap code-on-data", 16'h20F0, 16'h2200, 16'h3000, 16'h3010);
        do_protect("R3 overlap data-on-code", 16'h3000, 16'h3100, 16'h10FF, 16'h1200);
        do_protect("R2 second", 16'h3000, 16'h3100, 16'h4000, 16'h4080);
        do_protect("R5 empty code", 16'h5000, 16'h5000, 16'h6000, 16'h6100);
        do_protect("R5 empty data", 16'h5000, 16'h5100, 16'h6100, 16'h6000);
        do_protect("R2 third", 16'h5000, 16'h5100, 16'h6000, 16'h6100);
        do_protect("R2 fourth", 16'h7000, 16'h7100, 16'h8000, 16'h8100);
        do_protect("R4 table full", 16'h9000, 16'h9100, 16'hA000, 16'hA100);

        for (int a = 0; a < 16'hA000; a += 16'h40) do_getid("R8 sweep", 16'(a));
        for (int i = 0; i < NS; i++) begin
            do_getid("R8 code end-1", m_ch[i] - 16'd1);
            do_getid("R8 code end", m_ch[i]);
            do_getid("R8 code start-1", m_cl[i] - 16'd1);
            do_getid("R8 data start", m_dl[i]);
        end

        set_pc("R9 legal entry", 16'h3000, 1'b0);
        set_pc("R9 stay inside", 16'h3002, 1'b0);
        do_unprotect("R7 release second");
        set_pc("R9 leave", 16'hF000, 1'b0);
        do_getid("R7 released lookup", 16'h3000);
        do_unprotect("R7 release outside");
        do_protect("R6 reuse layout new number", 16'h3000, 16'h3100, 16'h4000, 16'h4080);

        // R11: protect wins over lookup
        getid_req_i = 1'b1; getid_addr_i = 16'h1000;
        do_protect("R11 protect over lookup", 16'h9000, 16'h9100, 16'hA000, 16'hA100);
        getid_req_i = 1'b0;

        // R11: release wins over lookup
        set_pc("R11 enter first", 16'h1000, 1'b0);
        set_pc("R11 inside first", 16'h1004, 1'b0);
        getid_req_i = 1'b1; getid_addr_i = 16'h5000;
        do_unprotect("R11 release over lookup");
        getid_req_i = 1'b0;
        set_pc("R11 leave", 16'hF000, 1'b0);
        do_getid("R11 first gone", 16'h1000);

        // R9/R12: jump into the middle of a live code span
        pc_i = 16'h5010;
        #1 chk("R12 not yet", 32'(core_rst_o), 32'd0);
        @(negedge clk);
        chk("R9 mid entry", 32'(core_rst_o), 32'd1);
        set_pc("R12 falls", 16'hF000, 1'b0);

        // R10: outside code touching private data
        mem_req_i = 1'b1; mem_addr_i = 16'h6000;
        #1 chk("R12 data not yet", 32'(core_rst_o), 32'd0);
        @(negedge clk);
        chk("R10 outside data read", 32'(core_rst_o), 32'd1);
        mem_req_i = 1'b0;
        @(negedge clk);
        chk("R12 data clears", 32'(core_rst_o), 32'd0);

        set_pc("R10 enter third", 16'h5000, 1'b0);
        mem_req_i = 1'b1; mem_addr_i = 16'h6010;
        set_pc("R10 own data read", 16'h5002, 1'b0);
        mem_we_i = 1'b1; mem_addr_i = 16'h5004;
        @(negedge clk);
        chk("R10 code write", 32'(core_rst_o), 32'd1);
        mem_req_i = 1'b0; mem_we_i = 1'b0;
        set_pc("R10 leave", 16'hF000, 1'b0);

        do_protect("R6 next number", 16'hB000, 16'hB100, 16'hC000, 16'hC100);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule